// File: doc/BRIEF.md
# SD Card Single-Block Data Mover

This engine carries one data block between a local byte buffer and a memory card on an SPI link. It runs after a separate command engine has issued the read-block or write-block command. It drives a byte-exchange port: it presents one transmit byte and receives the byte the card returned in the same exchange. It also drives the chip-select line and decides when the card is selected.

In read mode the engine clocks out 0xFF idle bytes and ignores what comes back until a start token arrives. It then hands each payload byte to the buffer through a valid/ready stream that carries the byte index. After the payload it drops the two check bytes. In write mode it sends the start token, pulls each payload byte from the buffer through a second valid/ready stream, and sends two 0xFF filler bytes in place of the check bytes. It then decodes the card's data-response token and waits while the card reports busy. A bounded wait counter limits both the token hunt and the busy wait. Every transfer ends by deselecting the card and clocking one more 0xFF byte.

A small side output gives the byte address for the command engine: the block number times 512. The payload length `BLK_LEN` is a parameter: 512 for data blocks, 16 for register blocks.

Top module: `sd_block_mover`

## Requirements
- R1: After reset the engine is idle: `busy`=0, `cs_n`=1, `x_req`=0, `done`=0.
- R2: In read mode every exchange before the start token 0xFE transmits 0xFF with `cs_n`=0, and no byte received before 0xFE reaches the read stream.
- R3: The read stream delivers exactly `BLK_LEN` bytes, in wire order, with `rd_idx` counting 0 upward. `rd_valid`, `rd_data` and `rd_idx` hold steady while `rd_ready` is low.
- R4: After the payload, a read performs exactly two more exchanges with `cs_n`=0, then one trailing 0xFF exchange with `cs_n`=1, and reports `err`=0.
- R5: In write mode the transmitted bytes are 0xFE, then the payload in index order (byte k taken from the source stream while `src_idx`=k), then 0xFF, 0xFF. `x_tx` and `cs_n` hold steady while `x_req` waits for `x_ack`.
- R6: The byte received in the exchange after the two filler bytes is the response token. If its low five bits equal 0x05, the write is accepted. If they equal 0x0B, the engine reports `err`=1. Any other value reports `err`=2. A rejected token goes straight to the trailing exchange with `cs_n`=1.
- R7: After an accepted token the engine sends 0xFF while the received byte is 0x00. The first nonzero byte ends the wait, and the next exchange is the trailing one with `cs_n`=1. A write that completes this way reports `err`=0.
- R8: If `WAIT_MAX` consecutive exchanges of the token hunt, or of the busy wait, all fail to end that phase, the engine reports `err`=3 and goes to the trailing exchange.
- R9: `cmd_addr` equals `blk_num` × 512 at all times.
- R10: `done` is high for exactly one cycle, after the trailing exchange, and `err` stays valid from then until the next start. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| dir_wr | input | 1 | 1 = write block, 0 = read block (sampled with start) |
| blk_num | input | BLKW | Block number for address generation |
| cmd_addr | output | 32 | Byte address for the command engine, blk_num × 512 |
| x_req | output | 1 | Byte exchange request, held until x_ack |
| x_tx | output | 8 | Byte to transmit |
| x_ack | input | 1 | Exchange finished, x_rx valid |
| x_rx | input | 8 | Byte received in the exchange |
| cs_n | output | 1 | Card chip select, active low |
| rd_valid | output | 1 | Read payload byte available |
| rd_ready | input | 1 | Buffer accepts the read byte |
| rd_data | output | 8 | Read payload byte |
| rd_idx | output | IW | Index of the read byte in the block |
| src_ready | output | 1 | Engine requests write byte at src_idx |
| src_valid | input | 1 | Buffer presents the write byte |
| src_data | input | 8 | Write payload byte |
| src_idx | output | IW | Index of the requested write byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 2 | 0 ok, 1 check-byte reject, 2 write reject, 3 timeout |

## Verification
The hardest situations to reach from the ports are the two wait-limit expiries and the reject paths. In all of them the engine leaves its normal sequence because of what the card sends. The bench drives a scripted card model that answers each exchange from a prepared byte queue. Each transfer can therefore start with garbage bytes before the token, return a chosen response token, hold busy for a chosen number of bytes, or never end a phase at all. Random exchange latency and random ready/valid gaps on both buffer streams stress the hold behaviour in the same runs. A stray start pulse in the middle of every transfer checks that it has no effect.

// File: rtl/sd_block_mover.sv
module sd_block_mover #(
  parameter int BLK_LEN  = 512,
  parameter int WAIT_MAX = 4096,
  parameter int BLKW     = 23,
  localparam int IW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1,
  localparam int CW = (WAIT_MAX > 2) ? $clog2(WAIT_MAX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dir_wr,
  input  logic [BLKW-1:0] blk_num,
  output logic [31:0]     cmd_addr,
  output logic            x_req,
  output logic [7:0]      x_tx,
  input  logic            x_ack,
  input  logic [7:0]      x_rx,
  output logic            cs_n,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [7:0]      rd_data,
  output logic [IW-1:0]   rd_idx,
  output logic            src_ready,
  input  logic            src_valid,
  input  logic [7:0]      src_data,
  output logic [IW-1:0]   src_idx,
  output logic            busy,
  output logic            done,
  output logic [1:0]      err
);
  typedef enum logic [3:0] {
    IDLE, HUNT, RDAT, PUSH, RCRC, WTOK, FETCH, WDAT, WCRC, RESP, BUSYW, TAIL
  } st_t;

  localparam logic [IW-1:0] LAST = IW'(BLK_LEN - 1);
  localparam logic [CW-1:0] CMAX = CW'(WAIT_MAX - 1);

  st_t           st;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic [7:0]    wbyte;

  assign cmd_addr  = 32'(blk_num) << 9;
  assign busy      = (st != IDLE);
  assign cs_n      = (st == IDLE) || (st == TAIL);
  assign x_req     = !(st inside {IDLE, PUSH, FETCH});
  assign x_tx      = (st == WTOK) ? 8'hFE : (st == WDAT) ? wbyte : 8'hFF;
  assign rd_valid  = (st == PUSH);
  assign rd_idx    = idx;
  assign src_ready = (st == FETCH);
  assign src_idx   = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      idx     <= '0;
      cnt     <= '0;
      wbyte   <= 8'h00;
      rd_data <= 8'h00;
      done    <= 1'b0;
      err     <= 2'd0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st  <= dir_wr ? WTOK : HUNT;
          err <= 2'd0;
          idx <= '0;
          cnt <= '0;
        end
        HUNT: if (x_ack) begin
          if (x_rx == 8'hFE) begin
            st <= RDAT;
          end else if (cnt == CMAX) begin
            err <= 2'd3;
            st  <= TAIL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RDAT: if (x_ack) begin
          rd_data <= x_rx;
          st      <= PUSH;
        end
        PUSH: if (rd_ready) begin
          if (idx == LAST) begin
            cnt <= '0;
            st  <= RCRC;
          end else begin
            idx <= idx + 1'b1;
            st  <= RDAT;
          end
        end
        RCRC: if (x_ack) begin
          if (cnt[0]) st <= TAIL;
          cnt <= cnt + 1'b1;
        end
        WTOK: if (x_ack) st <= FETCH;
        FETCH: if (src_valid) begin
          wbyte <= src_data;
          st    <= WDAT;
        end
        WDAT: if (x_ack) begin
          if (idx == LAST) begin
            cnt <= '0;
            st  <= WCRC;
          end else begin
            idx <= idx + 1'b1;
            st  <= FETCH;
          end
        end
        WCRC: if (x_ack) begin
          if (cnt[0]) begin
            cnt <= '0;
            st  <= RESP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RESP: if (x_ack) begin
          if (x_rx[4:0] == 5'h05) begin
            st <= BUSYW;
          end else begin
            err <= (x_rx[4:0] == 5'h0B) ? 2'd1 : 2'd2;
            st  <= TAIL;
          end
        end
        BUSYW: if (x_ack) begin
          if (x_rx != 8'h00) begin
            st <= TAIL;
          end else if (cnt == CMAX) begin
            err <= 2'd3;
            st  <= TAIL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TAIL: if (x_ack) begin
          done <= 1'b1;
          st   <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_block_mover_chk.sv
module sd_block_mover_chk #(
  parameter int IW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          cs_n,
  input logic          x_req,
  input logic          x_ack,
  input logic [7:0]    x_tx,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [7:0]    rd_data,
  input logic [IW-1:0] rd_idx,
  input logic          done,
  input logic [1:0]    err
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !x_req)); // R1

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_idx))); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (x_req && !x_ack) |=> (x_req && $stable(x_tx) && $stable(cs_n))); // R5

  AST_TAIL_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cs_n && x_ack)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(err)); // R10
endmodule

bind sd_block_mover sd_block_mover_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(cs_n), .x_req(x_req),
  .x_ack(x_ack), .x_tx(x_tx), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .rd_idx(rd_idx), .done(done), .err(err)
);

// File: tb/tb_sd_block_mover.sv
`timescale 1ns/1ps
module tb_sd_block_mover;
  localparam int LEN = 16;
  localparam int WM  = 20;
  localparam int IW  = 4;
  localparam int BW  = 23;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, dir_wr = 1'b0;
  logic [BW-1:0] blk_num = '0;
  logic [31:0] cmd_addr;
  logic x_req, x_ack = 1'b0, cs_n;
  logic [7:0] x_tx, x_rx = 8'h00;
  logic rd_valid, rd_ready = 1'b0, src_ready, src_valid = 1'b0;
  logic [7:0] rd_data, src_data = 8'h00;
  logic [IW-1:0] rd_idx, src_idx;
  logic busy, done;
  logic [1:0] err;

  sd_block_mover #(.BLK_LEN(LEN), .WAIT_MAX(WM), .BLKW(BW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr), .blk_num(blk_num),
    .cmd_addr(cmd_addr), .x_req(x_req), .x_tx(x_tx), .x_ack(x_ack), .x_rx(x_rx),
    .cs_n(cs_n), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_idx(rd_idx), .src_ready(src_ready), .src_valid(src_valid),
    .src_data(src_data), .src_idx(src_idx), .busy(busy), .done(done), .err(err)
  );

  int checks = 0, fails = 0;
  logic [7:0] resp_q [128];
  logic [7:0] exp_tx [128];
  logic [7:0] tx_log [128];
  logic       cs_log [128];
  logic [7:0] pay [LEN];
  logic [7:0] got [LEN];
  int n = 0, exp_n = 0, rd_cnt = 0, exp_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // card model: answers each exchange from resp_q with random latency
  initial forever begin
    @(negedge clk);
    if (x_req) begin
      repeat ($urandom % 3) @(negedge clk);
      x_rx = (n < 128) ? resp_q[n] : 8'hFF;
      if (n < 128) begin
        tx_log[n] = x_tx;
        cs_log[n] = cs_n;
      end
      n++;
      x_ack = 1'b1;
      @(negedge clk);
      x_ack = 1'b0;
    end
  end

  // buffer side: random ready/valid, record read stream
  initial forever begin
    @(negedge clk);
    rd_ready  = ($urandom % 3) != 0;
    src_valid = ($urandom % 3) != 0;
    src_data  = pay[src_idx];
    if (rd_valid && rd_ready) begin
      chk(rd_idx == IW'(rd_cnt), "R3 index order", int'(rd_idx), rd_cnt);
      if (rd_cnt < LEN) got[rd_cnt] = rd_data;
      rd_cnt++;
    end
  end

  task automatic push(input logic [7:0] rx, input logic [7:0] tx);
    resp_q[exp_n] = rx;
    exp_tx[exp_n] = tx;
    exp_n++;
  endtask

  task automatic prep_read(input int garb, input bit tmo);
    exp_n = 0;
    for (int i = 0; i < LEN; i++) pay[i] = 8'($urandom);
    if (tmo) begin
      for (int i = 0; i < WM; i++) push(8'hFF, 8'hFF);
      exp_err = 3;
    end else begin
      for (int i = 0; i < garb; i++) begin
        logic [7:0] g;
        g = 8'($urandom);
        if (g == 8'hFE) g = 8'hFC;
        push(g, 8'hFF);
      end
      push(8'hFE, 8'hFF);
      for (int i = 0; i < LEN; i++) push(pay[i], 8'hFF);
      push(8'($urandom), 8'hFF);
      push(8'($urandom), 8'hFF);
      exp_err = 0;
    end
    push(8'hFF, 8'hFF);
  endtask

  task automatic prep_write(input int nb, input logic [7:0] tok, input bit tmo);
    exp_n = 0;
    for (int i = 0; i < LEN; i++) pay[i] = 8'($urandom);
    push(8'hFF, 8'hFE);
    for (int i = 0; i < LEN; i++) push(8'hFF, pay[i]);
    push(8'hFF, 8'hFF);
    push(8'hFF, 8'hFF);
    push(tok, 8'hFF);
    if (tok[4:0] == 5'h05) begin
      if (tmo) begin
        for (int i = 0; i < WM; i++) push(8'h00, 8'hFF);
        exp_err = 3;
      end else begin
        for (int i = 0; i < nb; i++) push(8'h00, 8'hFF);
        push(8'($urandom) | 8'h01, 8'hFF);
        exp_err = 0;
      end
    end else begin
      exp_err = (tok[4:0] == 5'h0B) ? 1 : 2;
    end
    push(8'hFF, 8'hFF);
  endtask

  task automatic go(input bit wr, input string seq_tag, input string err_tag);
    int waited;
    n = 0;
    rd_cnt = 0;
    @(negedge clk);
    blk_num = BW'($urandom);
    dir_wr = wr;
    start = 1'b1;
    #1;
    chk(cmd_addr == {blk_num, 9'b0}, "R9 address", int'(cmd_addr), int'({blk_num, 9'b0}));
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    dir_wr = ~wr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      chk(1'b0, "watchdog expired", waited, 4000);
      return;
    end
    chk(int'(err) == exp_err, err_tag, int'(err), exp_err);
    chk(n == exp_n, {seq_tag, " exchange count (R10 stray start)"}, n, exp_n);
    for (int i = 0; i < exp_n && i < n && i < 128; i++) begin
      chk(tx_log[i] == exp_tx[i], {seq_tag, " tx byte"}, int'(tx_log[i]), int'(exp_tx[i]));
      chk(cs_log[i] == (i == exp_n - 1), {seq_tag, " chip select"}, int'(cs_log[i]),
          int'(i == exp_n - 1));
    end
    if (!wr) begin
      chk(rd_cnt == ((exp_err == 0) ? LEN : 0), "R3 byte count", rd_cnt,
          (exp_err == 0) ? LEN : 0);
      if (exp_err == 0)
        for (int i = 0; i < LEN; i++)
          chk(got[i] == pay[i], "R3 payload", int'(got[i]), int'(pay[i]));
    end
    @(negedge clk);
    chk(!done, "R10 done pulse width", int'(done), 0);
    chk(!busy && cs_n, "R10 idle after done", int'(busy), 0);
    chk(int'(err) == exp_err, "R10 err held", int'(err), exp_err);
  endtask

  initial begin
    void'($urandom(32'd7041));
    for (int i = 0; i < LEN; i++) pay[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(cs_n && !x_req && !busy && !done, "R1 reset state", {cs_n, x_req, busy, done}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !x_req && !busy, "R1 idle after reset", {cs_n, x_req, busy}, 3'b100);

    prep_read(0, 1'b0);              go(1'b0, "R4", "R4 read err");
    for (int t = 0; t < 6; t++) begin
      prep_read($urandom % 6, 1'b0); go(1'b0, "R2", "R4 read err");
    end
    prep_write(0, 8'h05, 1'b0);      go(1'b1, "R5", "R7 write err");
    for (int t = 0; t < 6; t++) begin
      prep_write($urandom % 6, {3'($urandom), 5'h05}, 1'b0);
      go(1'b1, "R7", "R7 write err");
    end
    prep_write(0, 8'h0B, 1'b0);      go(1'b1, "R6", "R6 check-byte reject");
    prep_write(0, 8'hEB, 1'b0);      go(1'b1, "R6", "R6 check-byte reject");
    prep_write(0, 8'h0D, 1'b0);      go(1'b1, "R6", "R6 write reject");
    prep_write(0, 8'h1F, 1'b0);      go(1'b1, "R6", "R6 write reject");
    prep_read(0, 1'b1);              go(1'b0, "R8", "R8 hunt timeout");
    prep_write(0, 8'h25, 1'b1);      go(1'b1, "R8", "R8 busy timeout");
    prep_read(WM - 1, 1'b0);         go(1'b0, "R8", "R8 token at last try");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL global watchdog actual=%0d expected=%0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule